// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load-Use Stall Unit

This block is the hazard logic of a five-stage in-order pipeline with the stages IF, RF, ALU, MEM and WB. Operands are read in the RF stage. The block compares each of the two source-register fields of the instruction in RF against the destination field and write-enable of the instructions in ALU, MEM and WB. For each operand it drives a 2-bit select code that steers the datapath's bypass multiplexer. It raises a stall request when an operand needs the result of a load that is still in the ALU stage.

The unit is purely combinational and holds no state. Its inputs come from the pipeline registers and the decoder. A store supplies its data from the register named in its destination field, so for a store the second operand is compared using that field in place of the ordinary second source field. Register 31 always reads as zero and is never a bypass source. An annulled slot reaches the unit with its write-enable cleared.

Select encoding, used by every requirement below: 2'b00 = register file, 2'b01 = ALU stage, 2'b10 = MEM stage, 2'b11 = WB stage.

Top module: `hz_bypass_unit`

## Requirements
- R1: When no eligible producer in ALU, MEM or WB matches a used source register, that operand's select is 2'b00 (register file).
- R2: A used source matching the ALU-stage destination with ALU write-enable set selects 2'b01.
- R3: A used source that matches only the MEM-stage destination (with MEM write-enable set) selects 2'b10.
- R4: A used source that matches only the WB-stage destination (with WB write-enable set) selects 2'b11. This holds even though WB writes the register file in the same cycle.
- R5: When several stages match, the youngest wins: ALU over MEM over WB.
- R6: A source field equal to 31 always selects 2'b00, and never stalls, whatever the producers hold.
- R7: A producer whose write-enable is 0 never matches, whatever its destination field holds.
- R8: When rf_is_store is 1, operand B is checked using rf_rc and rf_rb is ignored. When rf_is_store is 0, rf_rb is used and rf_rc is ignored.
- R9: stall is 1 when a used operand matches an ALU-stage producer that has write-enable set and alu_is_load = 1. The select for that operand still reads 2'b01.
- R10: stall is 0 when the matching load is in MEM or WB, or when the ALU-stage match is not a load.
- R11: An operand whose use flag is 0 selects 2'b00 and cannot cause a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rf_ra | input | 5 | First source field of the RF-stage instruction |
| rf_rb | input | 5 | Second source field of the RF-stage instruction |
| rf_rc | input | 5 | Destination field of the RF-stage instruction (data source for a store) |
| rf_use_a | input | 1 | The RF instruction reads operand A |
| rf_use_b | input | 1 | The RF instruction reads operand B |
| rf_is_store | input | 1 | The RF instruction is a store; operand B is taken from rf_rc |
| alu_wen | input | 1 | The ALU-stage instruction writes a register |
| alu_dst | input | 5 | ALU-stage destination field |
| alu_is_load | input | 1 | The ALU-stage instruction is a load |
| mem_wen | input | 1 | The MEM-stage instruction writes a register |
| mem_dst | input | 5 | MEM-stage destination field |
| wb_wen | input | 1 | The WB-stage instruction writes a register |
| wb_dst | input | 5 | WB-stage destination field |
| sel_a | output | 2 | Bypass select for operand A |
| sel_b | output | 2 | Bypass select for operand B |
| stall | output | 1 | Load-use stall request |

## Verification
On every evaluation the assertions check the following properties. A nonzero select always names a stage whose write-enable is set and whose destination equals the effective source. A zero-register or unused source always reads the register file. A stall always traces back to a load in ALU. A stage is never chosen while a younger stage also matches. Several behaviours show only in the bench's scenarios, which compare the outputs against an independent model: the exact choice among multiple producers, the store's swap of rf_rb for rf_rc, and the absence of a stall once the load has moved on to MEM.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int HZ_REG_W  = 5;
  localparam int HZ_NSTAGE = 3;
  localparam int HZ_NSRC   = 2;
  localparam int HZ_SEL_W  = $clog2(HZ_NSTAGE + 1);

  typedef enum logic [HZ_SEL_W-1:0] {
    BYP_RF  = 2'b00,
    BYP_ALU = 2'b01,
    BYP_MEM = 2'b10,
    BYP_WB  = 2'b11
  } byp_sel_e;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int REG_W  = 5,
  parameter int NSTAGE = 3
) (
  input  logic [REG_W-1:0]        src,
  input  logic                    used,
  input  logic [NSTAGE-1:0]       stg_wen,
  input  logic [NSTAGE*REG_W-1:0] stg_dst,
  output logic [NSTAGE-1:0]       hit
);
  localparam logic [REG_W-1:0] ZERO_REG = '1;

  logic eligible;
  assign eligible = used && (src != ZERO_REG);

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    assign hit[s] = eligible && stg_wen[s] &&
                    (stg_dst[s*REG_W +: REG_W] == src);
  end
endmodule

// File: rtl/hz_prio_sel.sv
module hz_prio_sel #(
  parameter int NSTAGE = 3,
  localparam int SEL_W = $clog2(NSTAGE + 1)
) (
  input  logic [NSTAGE-1:0] hit,
  output logic [SEL_W-1:0]  sel
);
  // index 0 is the youngest stage; scanning oldest to youngest lets the youngest overwrite
  always_comb begin
    sel = '0;
    for (int i = NSTAGE - 1; i >= 0; i--) begin
      if (hit[i]) sel = SEL_W'(i + 1);
    end
  end
endmodule

// File: rtl/hz_load_stall.sv
module hz_load_stall #(
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0] youngest_hit,
  input  logic            youngest_is_load,
  output logic            stall
);
  assign stall = youngest_is_load && (|youngest_hit);
endmodule

// File: rtl/hz_bypass_unit.sv
module hz_bypass_unit #(
  parameter int REG_W = hz_pkg::HZ_REG_W,
  localparam int NSTAGE = hz_pkg::HZ_NSTAGE,
  localparam int NSRC   = hz_pkg::HZ_NSRC,
  localparam int SEL_W  = $clog2(NSTAGE + 1)
) (
  input  logic [REG_W-1:0] rf_ra,
  input  logic [REG_W-1:0] rf_rb,
  input  logic [REG_W-1:0] rf_rc,
  input  logic             rf_use_a,
  input  logic             rf_use_b,
  input  logic             rf_is_store,
  input  logic             alu_wen,
  input  logic [REG_W-1:0] alu_dst,
  input  logic             alu_is_load,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             wb_wen,
  input  logic [REG_W-1:0] wb_dst,
  output logic [SEL_W-1:0] sel_a,
  output logic [SEL_W-1:0] sel_b,
  output logic             stall
);
  logic [NSTAGE-1:0]       stg_wen;
  logic [NSTAGE*REG_W-1:0] stg_dst;
  logic [REG_W-1:0]        src   [NSRC];
  logic [NSRC-1:0]         used;
  logic [NSTAGE-1:0]       hit   [NSRC];
  logic [SEL_W-1:0]        sel   [NSRC];
  logic [NSRC-1:0]         young_hit;

  assign stg_wen = {wb_wen, mem_wen, alu_wen};
  assign stg_dst = {wb_dst, mem_dst, alu_dst};

  assign src[0]  = rf_ra;
  assign src[1]  = rf_is_store ? rf_rc : rf_rb;
  assign used    = {rf_use_b, rf_use_a};

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    hz_src_match #(.REG_W(REG_W), .NSTAGE(NSTAGE)) u_match (
      .src(src[k]), .used(used[k]), .stg_wen(stg_wen),
      .stg_dst(stg_dst), .hit(hit[k])
    );
    hz_prio_sel #(.NSTAGE(NSTAGE)) u_prio (
      .hit(hit[k]), .sel(sel[k])
    );
    assign young_hit[k] = hit[k][0];
  end

  hz_load_stall #(.NSRC(NSRC)) u_stall (
    .youngest_hit(young_hit), .youngest_is_load(alu_is_load), .stall(stall)
  );

  assign sel_a = sel[0];
  assign sel_b = sel[1];
endmodule

// File: rtl/hz_bypass_chk.sv
module hz_bypass_chk #(
  parameter int REG_W = 5,
  parameter int SEL_W = 2
) (
  input logic [REG_W-1:0] rf_ra,
  input logic [REG_W-1:0] rf_rb,
  input logic [REG_W-1:0] rf_rc,
  input logic             rf_use_a,
  input logic             rf_use_b,
  input logic             rf_is_store,
  input logic             alu_wen,
  input logic [REG_W-1:0] alu_dst,
  input logic             alu_is_load,
  input logic             mem_wen,
  input logic [REG_W-1:0] mem_dst,
  input logic             wb_wen,
  input logic [REG_W-1:0] wb_dst,
  input logic [SEL_W-1:0] sel_a,
  input logic [SEL_W-1:0] sel_b,
  input logic             stall
);
  localparam logic [REG_W-1:0] ZR = '1;
  logic [REG_W-1:0] eb;
  assign eb = rf_is_store ? rf_rc : rf_rb;

  always_comb begin
    // R6 / R11: ineligible sources read the register file
    a_r6_zero_reg_a: assert (!(rf_ra == ZR) || sel_a == 2'b00);
    a_r6_zero_reg_b: assert (!(eb == ZR) || sel_b == 2'b00);
    a_r11_unused_a:  assert (rf_use_a || sel_a == 2'b00);
    a_r11_unused_b:  assert (rf_use_b || sel_b == 2'b00);
    // R2 / R3 / R4 / R7: a chosen stage really produces the source
    a_r2_alu_valid:  assert (sel_a != 2'b01 || (alu_wen && alu_dst == rf_ra));
    a_r3_mem_valid:  assert (sel_b != 2'b10 || (mem_wen && mem_dst == eb));
    a_r4_wb_valid:   assert (sel_a != 2'b11 || (wb_wen && wb_dst == rf_ra));
    a_r7_wen_b_wb:   assert (sel_b != 2'b11 || wb_wen);
    // R5: no older stage chosen while a younger one matches
    a_r5_prio_a:     assert (!(sel_a[1] && alu_wen && alu_dst == rf_ra));
    a_r5_prio_b:     assert (!(sel_b == 2'b11 && mem_wen && mem_dst == eb));
    // R9: a stall always comes from a load in ALU with a bypass from ALU
    a_r9_stall_src:  assert (!stall || (alu_is_load && alu_wen &&
                             (sel_a == 2'b01 || sel_b == 2'b01)));
  end
endmodule

bind hz_bypass_unit hz_bypass_chk #(.REG_W(REG_W), .SEL_W(SEL_W)) u_chk (
  .rf_ra(rf_ra), .rf_rb(rf_rb), .rf_rc(rf_rc), .rf_use_a(rf_use_a),
  .rf_use_b(rf_use_b), .rf_is_store(rf_is_store), .alu_wen(alu_wen),
  .alu_dst(alu_dst), .alu_is_load(alu_is_load), .mem_wen(mem_wen),
  .mem_dst(mem_dst), .wb_wen(wb_wen), .wb_dst(wb_dst),
  .sel_a(sel_a), .sel_b(sel_b), .stall(stall)
);

// File: tb/sim_hz_bypass_unit.sv
`timescale 1ns/1ps
module sim_hz_bypass_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0] rf_ra, rf_rb, rf_rc, alu_dst, mem_dst, wb_dst;
  logic rf_use_a, rf_use_b, rf_is_store, alu_wen, alu_is_load, mem_wen, wb_wen;
  logic [1:0] sel_a, sel_b;
  logic stall;
  int checks = 0, failures = 0;
  bit done = 0;

  hz_bypass_unit u0 (.*);

  function automatic int ref_sel(int r, bit u);
    if (!u || r == 31) return 0;
    if (alu_wen && alu_dst == r) return 1;
    if (mem_wen && mem_dst == r) return 2;
    if (wb_wen && wb_dst == r) return 3;
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // compare all outputs against the model, tagging by requirement
  task automatic step(string tag);
    int ea, eb, es, bsrc;
    @(negedge clk);
    bsrc = rf_is_store ? int'(rf_rc) : int'(rf_rb);
    ea = ref_sel(rf_ra, rf_use_a);
    eb = ref_sel(bsrc, rf_use_b);
    es = (alu_is_load && (ea == 1 || eb == 1)) ? 1 : 0;
    chk({tag, " sel_a"}, sel_a, ea);
    chk({tag, " sel_b"}, sel_b, eb);
    chk({tag, " stall"}, stall, es);
    @(posedge clk); #1;
  endtask

  task automatic setp(int a, int b, int c, bit ua, bit ub, bit st,
                      bit aw, int ad, bit al, bit mw, int md, bit ww, int wd);
    rf_ra = 5'(a); rf_rb = 5'(b); rf_rc = 5'(c);
    rf_use_a = ua; rf_use_b = ub; rf_is_store = st;
    alu_wen = aw; alu_dst = 5'(ad); alu_is_load = al;
    mem_wen = mw; mem_dst = 5'(md); wb_wen = ww; wb_dst = 5'(wd);
  endtask

  initial begin
    setp(0,0,0,0,0,0,0,0,0,0,0,0,0);
    @(posedge clk); #1;
    step("R1 reset idle");
    setp(1,2,3,1,1,0,1,4,0,1,5,1,6);  step("R1 no match");
    setp(1,2,3,1,1,0,1,1,0,1,5,1,6);  step("R2 alu match a");
    setp(1,2,3,1,1,0,1,9,0,1,2,1,6);  step("R3 mem match b");
    setp(7,2,3,1,1,0,1,9,0,1,8,1,7);  step("R4 wb match a");
    setp(4,4,3,1,1,0,1,4,0,1,4,1,4);  step("R5 all match");
    setp(4,4,3,1,1,0,0,4,0,1,4,1,4);  step("R5 mem over wb");
    setp(31,31,3,1,1,0,1,31,1,1,31,1,31); step("R6 zero reg");
    setp(5,5,3,1,1,0,0,5,1,0,5,0,5);  step("R7 wen clear");
    setp(1,2,9,1,1,1,1,2,0,1,9,0,0);  step("R8 store uses rc");
    setp(1,9,2,1,1,0,1,2,0,1,9,0,0);  step("R8 non-store uses rb");
    setp(3,2,3,1,1,0,1,3,1,0,0,0,0);  step("R9 load-use a");
    setp(1,2,6,1,1,1,1,6,1,0,0,0,0);  step("R9 load-use store data");
    setp(3,2,3,1,1,0,0,0,0,1,3,0,0);  step("R10 load in mem");
    setp(3,2,3,1,1,0,1,3,0,0,0,0,0);  step("R10 alu not load");
    setp(3,3,3,0,0,0,1,3,1,1,3,1,3);  step("R11 unused");
    for (int n = 0; n < 3000; n++) begin
      int pool[4] = '{1, 2, 3, 31};
      setp(pool[$urandom%4], pool[$urandom%4], pool[$urandom%4],
           1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), pool[$urandom%4], 1'($urandom),
           1'($urandom), pool[$urandom%4], 1'($urandom), pool[$urandom%4]);
      step("R5 R9 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule